// File: doc/BRIEF.md
# Serial Control Register Port

This block is a synchronous serial slave with four wires. It gives a host read and write access to a small bank of 8-bit control registers. The host pulls the chip select low and clocks bytes in on the serial data input, least significant bit first. The first byte of every transaction is a command byte. Its top bit chooses write or read, and its low five bits give the register address where the transfer starts. Each later byte is written to, or read from, the current address, and the address then steps up by one and wraps from 1FH to 00H.

The block holds the writable registers together with their reset defaults and shows their contents on a flat parallel bus. Two decoded fields are also brought out on their own. The serial pins are sampled by a system clock through a synchroniser, and edges of the serial clock are found in that clock domain. The serial clock must therefore run well below the system clock; the bench keeps each serial clock phase at six system clocks.

Top module: `scrp_top`

## Requirements
- R1: After reset, register 00H holds 7FH, register 01H holds 03H, registers 02H through 08H hold 00H, and the serial output is low.
- R2: The first byte after chip select falls is a command byte sent least significant bit first. Bit 7 = 1 selects write and bit 7 = 0 selects read. Bits 4:0 give the start address. Bits 6:5 have no effect.
- R3: In a write transaction, each complete byte after the command is stored at the current address, and the address then increments by one, wrapping from 1FH to 00H.
- R4: In a read transaction, the serial output presents bit k of the register at the current address (LSB first). Each bit changes only after a falling serial clock edge, so it is stable at the next rising edge. The address increments after each byte.
- R5: During a read transaction the serial input data has no effect, and no register changes.
- R6: Registers 09H and 0AH read back a fixed identification code, 1AH and C3H with the default parameters, and writes to them have no effect.
- R7: Writes to addresses 0BH through 1FH are ignored, and reads from them return 00H.
- R8: If chip select rises in the middle of a byte, that partial byte is discarded, and the next byte after chip select falls again is treated as a command.
- R9: The serial output is low while chip select is high, during the command byte, and throughout a write transaction.
- R10: cfg_o carries register n in bits 8n+7:8n for n = 0 to 8. pix16_o equals bit 4 of register 01H, and cc_mode_o equals bits 1:0 of register 02H.
- R11: Serial clock edges while chip select is high change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the host |
| csn_i | input | 1 | Active-low chip select |
| sdi_i | input | 1 | Serial data in, LSB first |
| sdo_o | output | 1 | Serial data out, LSB first |
| cfg_o | output | 72 | Contents of registers 00H to 08H |
| pix16_o | output | 1 | Selects 16-bit pixel input (register 01H bit 4) |
| cc_mode_o | output | 2 | Caption mode: 0 off, 1 first field, 2 second field, 3 both |

## Verification
A wrong bit counter or a wrong phase shows up within one byte. Data lands one register away on cfg_o, or read bytes come back rotated on sdo_o. The bench sees this at the first compare after chip select rises. A wrong address or a wrong direction flag corrupts a register that no transaction addressed, and the reference model compares every register on each idle clock. An abort that is handled badly shows up in the very next transaction, because its first data byte lands at an address that the command byte did not name.

// File: rtl/scrp_pkg.sv
package scrp_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 5;
    localparam int CNT_W  = $clog2(DATA_W);

    typedef enum logic {PH_CMD, PH_DATA} phase_e;

    typedef struct packed {
        phase_e             phase;
        logic               wr_mode;
        logic [CNT_W-1:0]   bit_cnt;
        logic [DATA_W-1:0]  shift;
        logic [ADDR_W-1:0]  addr;
        logic               sdo;
        logic               sck_prev;
    } port_state_t;

    function automatic logic [DATA_W-1:0] reg_default(input int idx);
        case (idx)
            0:       return 8'h7F;
            1:       return 8'h03;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/scrp_sync.sv
module scrp_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= {STAGES{RST_VAL}};
        else        stage_q <= {stage_q[STAGES-2:0], d};
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/scrp_regfile.sv
module scrp_regfile
    import scrp_pkg::*;
#(
    parameter int          NUM_RW  = 9,
    parameter logic [15:0] ID_CODE = 16'hC31A
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [ADDR_W-1:0]        raddr,
    output logic [DATA_W-1:0]        rdata,
    output logic [NUM_RW*DATA_W-1:0] regs_flat
);
    localparam logic [ADDR_W-1:0] ID_LO_ADDR = ADDR_W'(NUM_RW);
    localparam logic [ADDR_W-1:0] ID_HI_ADDR = ADDR_W'(NUM_RW + 1);

    for (genvar g = 0; g < NUM_RW; g++) begin : g_cell
        logic [DATA_W-1:0] cell_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                cell_q <= reg_default(g);
            else if (we && waddr == ADDR_W'(g))        cell_q <= wdata;
        end
        assign regs_flat[g*DATA_W +: DATA_W] = cell_q;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_RW; i++) begin
            if (raddr == ADDR_W'(i)) rdata = regs_flat[i*DATA_W +: DATA_W];
        end
        if (raddr == ID_LO_ADDR) rdata = ID_CODE[7:0];
        if (raddr == ID_HI_ADDR) rdata = ID_CODE[15:8];
    end
endmodule

// File: rtl/scrp_top.sv
module scrp_top
    import scrp_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter int          NUM_RW      = 9,
    parameter logic [15:0] ID_CODE     = 16'hC31A
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sck_i,
    input  logic                     csn_i,
    input  logic                     sdi_i,
    output logic                     sdo_o,
    output logic [NUM_RW*DATA_W-1:0] cfg_o,
    output logic                     pix16_o,
    output logic [1:0]               cc_mode_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic              sck_s, csn_s, sdi_s;
    logic              sck_rise, sck_fall, selected, in_data;
    logic [DATA_W-1:0] byte_next, rdata;
    logic              we;
    port_state_t       st_d, st_q;

    scrp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck_i, csn_i, sdi_i}),
        .q     ({sck_s, csn_s, sdi_s})
    );

    scrp_regfile #(.NUM_RW(NUM_RW), .ID_CODE(ID_CODE)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (we),
        .waddr     (st_q.addr),
        .wdata     (byte_next),
        .raddr     (st_q.addr),
        .rdata     (rdata),
        .regs_flat (cfg_o)
    );

    assign sck_rise  = sck_s & ~st_q.sck_prev;
    assign sck_fall  = ~sck_s & st_q.sck_prev;
    assign selected  = ~csn_s;
    assign byte_next = {sdi_s, st_q.shift[DATA_W-1:1]};
    assign in_data   = (st_q.phase == PH_DATA);

    always_comb begin
        st_d          = st_q;
        we            = 1'b0;
        st_d.sck_prev = sck_s;
        if (!selected) begin
            st_d.phase   = PH_CMD;
            st_d.wr_mode = 1'b0;
            st_d.bit_cnt = '0;
            st_d.shift   = '0;
            st_d.sdo     = 1'b0;
        end else begin
            if (sck_rise) begin
                st_d.shift   = byte_next;
                st_d.bit_cnt = st_q.bit_cnt + CNT_W'(1);
                if (st_q.bit_cnt == LAST_BIT) begin
                    if (st_q.phase == PH_CMD) begin
                        st_d.phase   = PH_DATA;
                        st_d.wr_mode = byte_next[DATA_W-1];
                        st_d.addr    = byte_next[ADDR_W-1:0];
                    end else begin
                        we        = st_q.wr_mode;
                        st_d.addr = st_q.addr + ADDR_W'(1);
                    end
                end
            end
            if (sck_fall) begin
                st_d.sdo = (in_data && !st_q.wr_mode) ? rdata[st_q.bit_cnt] : 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.phase    <= PH_CMD;
        end else begin
            st_q          <= st_d;
        end
    end

    assign sdo_o     = st_q.sdo;
    assign pix16_o   = cfg_o[1*DATA_W + 4];
    assign cc_mode_o = cfg_o[2*DATA_W +: 2];
endmodule

// File: rtl/scrp_checker.sv
module scrp_checker #(
    parameter int CFG_W = 72,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             csn_s,
    input logic             sck_rise,
    input logic             sck_fall,
    input logic             sdo_o,
    input logic [CFG_W-1:0] cfg_o,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             in_data
);
    AST_SDO_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> !sdo_o); // R9

    AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!csn_s && !sck_fall) |=> $stable(sdo_o)); // R4

    AST_CFG_HOLD_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> $stable(cfg_o)); // R11

    AST_CFG_WRITE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!csn_s && !sck_rise) |=> $stable(cfg_o)); // R3

    AST_FRESH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> (bit_cnt == '0 && !in_data)); // R8
endmodule

bind scrp_top scrp_checker #(.CFG_W(NUM_RW*scrp_pkg::DATA_W), .CNT_W(scrp_pkg::CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .csn_s    (csn_s),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .sdo_o    (sdo_o),
    .cfg_o    (cfg_o),
    .bit_cnt  (st_q.bit_cnt),
    .in_data  (in_data)
);

// File: tb/tb_scrp_top.sv
module tb_scrp_top;
    localparam int NRW  = 9;
    localparam int HALF = 6;
    localparam logic [7:0] ID_LO = 8'h1A;
    localparam logic [7:0] ID_HI = 8'hC3;

    typedef logic [7:0] bq_t[$];

    logic clk = 0, rst_n = 0, sck = 0, csn = 1, sdi = 0;
    logic sdo, pix16;
    logic [NRW*8-1:0] cfg;
    logic [1:0] cc;

    always #10 clk = ~clk;

    scrp_top dut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .csn_i(csn), .sdi_i(sdi),
        .sdo_o(sdo), .cfg_o(cfg), .pix16_o(pix16), .cc_mode_o(cc)
    );

    int errors = 0, checks = 0, settle = 0, cyc = 0;
    bit done = 0, compare_en = 0;
    logic [2:0] prev_pins = 3'b010;
    logic [7:0] exp_mem [32];

    function automatic logic [7:0] rd_exp(input int a);
        if (a < NRW) return exp_mem[a];
        if (a == 9)  return ID_LO;
        if (a == 10) return ID_HI;
        return 8'h00;
    endfunction

    function automatic logic [NRW*8-1:0] exp_flat();
        logic [NRW*8-1:0] f;
        for (int i = 0; i < NRW; i++) f[i*8 +: 8] = exp_mem[i];
        return f;
    endfunction

    task automatic check8(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_xfer(input logic b, output logic rx);
        sck = 0; sdi = b;
        wait_clk(HALF);
        rx = sdo;
        sck = 1;
        wait_clk(HALF);
    endtask

    task automatic xfer_byte(input logic [7:0] tx, output logic [7:0] rx);
        logic r;
        for (int i = 0; i < 8; i++) begin
            bit_xfer(tx[i], r);
            rx[i] = r;
        end
    endtask

    task automatic cs_start();
        csn = 0; wait_clk(HALF);
    endtask

    task automatic cs_end();
        sck = 0; wait_clk(HALF);
        csn = 1; wait_clk(HALF);
    endtask

    task automatic wr_txn(input logic [7:0] cmd, input bq_t data);
        logic [7:0] rx;
        int a = int'(cmd[4:0]);
        cs_start();
        xfer_byte(cmd, rx);
        check8("R9 sdo during command byte", rx, 8'h00);
        foreach (data[k]) begin
            xfer_byte(data[k], rx);
            check8("R9 sdo during write byte", rx, 8'h00);
            if (a < NRW) exp_mem[a] = data[k];
            a = (a + 1) % 32;
        end
        cs_end();
    endtask

    task automatic rd_txn(input string tag, input logic [7:0] cmd, input int n, input logic [7:0] junk);
        logic [7:0] rx;
        int a = int'(cmd[4:0]);
        cs_start();
        xfer_byte(cmd, rx);
        check8("R9 sdo during read command", rx, 8'h00);
        for (int k = 0; k < n; k++) begin
            xfer_byte(junk, rx);
            check8(tag, rx, rd_exp(a));
            a = (a + 1) % 32;
        end
        cs_end();
    endtask

    task automatic abort_txn(input logic [7:0] cmd, input logic [7:0] part, input int nbits);
        logic [7:0] rx;
        logic r;
        cs_start();
        if (nbits > 8) begin
            xfer_byte(cmd, rx);
            for (int i = 0; i < nbits - 8; i++) bit_xfer(part[i], r);
        end else begin
            for (int i = 0; i < nbits; i++) bit_xfer(cmd[i], r);
        end
        cs_end();
    endtask

    // Reference comparison on every settled idle clock (R10, R1, R5, R7, R11)
    always @(negedge clk) begin
        if ({sck, csn, sdi} != prev_pins) settle = 0;
        else if (settle < 1000) settle++;
        prev_pins = {sck, csn, sdi};
        if (compare_en && csn && settle >= 4) begin
            checks++;
            if (cfg !== exp_flat() || pix16 !== exp_mem[1][4] || cc !== exp_mem[2][1:0] || sdo !== 1'b0) begin
                errors++;
                $display("FAIL R10 cfg=%h pix16=%b cc=%b sdo=%b expected cfg=%h pix16=%b cc=%b sdo=0",
                         cfg, pix16, cc, sdo, exp_flat(), exp_mem[1][4], exp_mem[2][1:0]);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) exp_mem[i] = 8'h00;
        exp_mem[0] = 8'h7F;
        exp_mem[1] = 8'h03;
        wait_clk(5);
        rst_n = 1;
        wait_clk(5);

        // R1 reset state
        check8("R1 reg00 default", cfg[7:0], 8'h7F);
        check8("R1 reg01 default", cfg[15:8], 8'h03);
        checks++;
        if (cfg[NRW*8-1:16] !== '0) begin
            errors++;
            $display("FAIL R1 actual=%h expected=0", cfg[NRW*8-1:16]);
        end
        check8("R9 sdo after reset", {7'd0, sdo}, 8'h00);
        compare_en = 1;

        // R4 R6 R7: read full range starting at 00H
        rd_txn("R4 read sweep", 8'h00, 12, 8'h00);

        // R3: multi-byte write with auto-increment
        wr_txn(8'h82, '{8'hA5, 8'h3C, 8'h01});
        wr_txn(8'h81, '{8'h10});
        check8("R10 pix16 field", {7'd0, pix16}, 8'h01);
        check8("R10 cc mode field", {6'd0, cc}, 8'h01);
        rd_txn("R3 readback", 8'h01, 4, 8'h00);

        // R2: bits 6:5 of the command have no effect
        wr_txn(8'hE5, '{8'h77});
        rd_txn("R2 ignored command bits", 8'h65, 1, 8'h00);

        // R5: read ignores incoming data
        rd_txn("R5 read with ones on input", 8'h03, 2, 8'hFF);
        rd_txn("R5 second read unchanged", 8'h02, 4, 8'h5A);

        // R6 R7: writes to identification and unimplemented addresses
        wr_txn(8'h89, '{8'h00, 8'h00, 8'h11, 8'h22});
        rd_txn("R6 id and R7 unimplemented", 8'h09, 4, 8'h00);

        // R3 R7: wrap from 1FH to 00H
        wr_txn(8'h9F, '{8'h12, 8'h34});
        rd_txn("R3 wrap readback", 8'h1E, 3, 8'h00);

        // R8: abort inside command byte and inside data byte
        abort_txn(8'h86, 8'h00, 4);
        wr_txn(8'h86, '{8'hC3});
        abort_txn(8'h87, 8'hFF, 13);
        rd_txn("R8 abort handling", 8'h06, 2, 8'h00);

        // R11: serial clock toggling while deselected
        for (int k = 0; k < 12; k++) begin
            sck = ~sck; sdi = k[1];
            wait_clk(HALF);
        end
        sck = 0; wait_clk(HALF);
        rd_txn("R11 registers unchanged", 8'h00, 9, 8'h00);

        wait_clk(10);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule